// File: doc/BRIEF.md
# I/O Page Register Bank

This block holds the byte-wide control registers of a handheld console's I/O page and serves them over a simple synchronous bus. The bus has one address, write data, a write strobe and combinational read data. Each known register reads back as its stored byte ORed with a fixed constant. The constant sets the unimplemented bits to one. Addresses the bank does not know read as 0xFF. The interrupt-enable register sits at the top address of the map, outside the page. It is held apart from the page and reads back exactly as written.

Some writes act on other engines instead of, or as well as, storing data. They are reported as one-cycle output strobes. A divider write only requests a divider reset. A transfer-register write starts a copy whose source is the written byte times 256. Interrupt-flag and interrupt-enable writes request an interrupt re-evaluation. Sound-register writes are forwarded to the sound engine, but only while the audio master enable is set. When it is clear, the bank stores zero and forwards nothing.

Every address falls into one of nine access classes, and the decoder names the class for the current address:
- CLS_NONE is an unknown address inside the page.
- CLS_PLAIN is ordinary storage.
- CLS_SOUND is a gated sound register.
- CLS_AUDCTL is the audio master control.
- CLS_IFLAG is the interrupt flag.
- CLS_DIV is the divider.
- CLS_DMA is the transfer start.
- CLS_IE is the interrupt enable.
- CLS_OUTSIDE is an address above the page other than the enable register.

The bank holds no state machine. On every write, the class selects both the stored value and the strobe that fires.

Top module: `iob_regbank`

## Requirements
- R1: After reset, reads return these values: 0x26→0xF1, 0x40→0x91, 0x47→0xFC, 0x48→0xFF, 0x49→0xFF, 0x24→0x77, 0x25→0xF3, 0x0F→0xE1, 0x10→0x80, 0x11→0xBF, 0x12→0xF3, 0x13→0xFF, 0x14→0xBF, 0x16→0x3F, 0x19→0xBF, 0x1A→0x7F, 0x1B→0xFF, 0x1C→0x9F, 0x1E→0xBF, 0x20→0xFF, 0x23→0xBF and 0xFF→0x00. All other known registers read as their mask, and the audio master enable is set.
- R2: A read of a known page register returns its stored byte ORed with its mask:
  - 0x02: 0x7E
  - 0x07: 0xF8
  - 0x0F: 0xE0
  - 0x10: 0x80
  - 0x11 and 0x16: 0x3F
  - 0x13, 0x18, 0x1B, 0x1D and 0x20: 0xFF
  - 0x14, 0x19, 0x1E and 0x23: 0xBF
  - 0x1A: 0x7F
  - 0x1C: 0x9F
  - 0x26: 0x70
  - 0x41: 0x80
  - 0x01, 0x04–0x06, 0x12, 0x17, 0x21, 0x22, 0x24, 0x25, 0x40, 0x42, 0x43, 0x45 and 0x47–0x4B: 0x00
- R3: All other addresses read 0xFF, except 0xFF itself. This covers the in-page addresses outside the known set, including 0x46, and 0x80–0xFE. In-page writes to them are stored. Writes to 0x80–0xFE change no register.
- R4: The sound registers are 0x10–0x14, 0x16–0x1E and 0x20–0x25. While the audio master enable is clear, a write to one of them stores 0x00 and raises no sound strobe.
- R5: A write to 0x26 stores bit 7 of the data and sets bits 6:4 to zero. Bits 3:0 keep their previous value. Bit 7 becomes the audio master enable.
- R6: A write to 0x0F stores the data with bits 7:5 forced to 1 and raises the interrupt-update strobe.
- R7: The interrupt enable at 0xFF reads back the written byte unmasked, and its write raises the interrupt-update strobe.
- R8: A write to 0x04 stores nothing, so 0x04 keeps reading 0x00. It raises the divider-reset strobe.
- R9: A write to 0x46 raises the transfer-start strobe with a source address equal to the data shifted left by 8.
- R10: The wave bytes at 0x30–0x3F store and read back any value unmasked.
- R11: Every strobe is high for exactly the one cycle after the clock edge that accepts the write. While the sound strobe is high, the sound address and data outputs carry that write's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Combinational read data |
| audio_en | output | 1 | Audio master enable |
| snd_we | output | 1 | Forwarded sound-register write strobe |
| snd_addr | output | 8 | Address of the forwarded sound write |
| snd_wdata | output | 8 | Data of the forwarded sound write |
| div_reset | output | 1 | Divider reset request |
| dma_start | output | 1 | Transfer start request |
| dma_src | output | 16 | Transfer source address |
| irq_update | output | 1 | Interrupt re-evaluation request |

## Verification
Read data is combinational. A stored value is due on bus_rdata as soon as the address is presented in any cycle after the accepting edge, so the bench sets the address at a falling edge and compares a little later. Strobes come from a register stage. Each one is due in the cycle that follows the accepting edge and is gone one cycle later. The bench releases bus_we at the next falling edge and samples all strobes there, in every write of the sweep. Each address is written and read back twice: once with the audio enable set and once with it clear. The expected value comes from a model in the bench built on the class and mask lists above.

// File: rtl/iob_pkg.sv
package iob_pkg;
    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int PAGE    = 128;

    localparam logic [AW-1:0] A_DIV    = 8'h04;
    localparam logic [AW-1:0] A_IFLAG  = 8'h0F;
    localparam logic [AW-1:0] A_AUDCTL = 8'h26;
    localparam logic [AW-1:0] A_DMA    = 8'h46;
    localparam logic [AW-1:0] A_IE     = 8'hFF;

    typedef enum logic [3:0] {
        CLS_NONE, CLS_PLAIN, CLS_SOUND, CLS_AUDCTL, CLS_IFLAG,
        CLS_DIV, CLS_DMA, CLS_IE, CLS_OUTSIDE
    } reg_class_e;

    function automatic reg_class_e classify(input logic [AW-1:0] a);
        reg_class_e c;
        c = CLS_NONE;
        if (a == A_IE)                          c = CLS_IE;
        else if (a >= 8'(PAGE))                 c = CLS_OUTSIDE;
        else if (a == A_DIV)                    c = CLS_DIV;
        else if (a == A_IFLAG)                  c = CLS_IFLAG;
        else if (a == A_AUDCTL)                 c = CLS_AUDCTL;
        else if (a == A_DMA)                    c = CLS_DMA;
        else if ((a >= 8'h10 && a <= 8'h25) && a != 8'h15 && a != 8'h1F)
                                                c = CLS_SOUND;
        else if (a >= 8'h30 && a <= 8'h3F)      c = CLS_PLAIN;
        else if (a == 8'h01 || a == 8'h02 || a == 8'h05 || a == 8'h06 ||
                 a == 8'h07 || a == 8'h40 || a == 8'h41 || a == 8'h42 ||
                 a == 8'h43 || a == 8'h45 || (a >= 8'h47 && a <= 8'h4B))
                                                c = CLS_PLAIN;
        return c;
    endfunction

    function automatic logic [DW-1:0] read_mask(input logic [AW-1:0] a);
        logic [DW-1:0] m;
        unique case (a)
            8'h02:                             m = 8'h7E;
            8'h07:                             m = 8'hF8;
            8'h0F:                             m = 8'hE0;
            8'h10, 8'h41:                      m = 8'h80;
            8'h11, 8'h16:                      m = 8'h3F;
            8'h13, 8'h18, 8'h1B, 8'h1D, 8'h20: m = 8'hFF;
            8'h14, 8'h19, 8'h1E, 8'h23:        m = 8'hBF;
            8'h1A:                             m = 8'h7F;
            8'h1C:                             m = 8'h9F;
            8'h26:                             m = 8'h70;
            default:                           m = 8'h00;
        endcase
        return m;
    endfunction

    function automatic logic [DW-1:0] reset_value(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        unique case (a)
            8'h0F:                      v = 8'hE1;
            8'h10:                      v = 8'h80;
            8'h11, 8'h14, 8'h19, 8'h1E, 8'h23: v = 8'hBF;
            8'h12, 8'h13, 8'h25:        v = 8'hF3;
            8'h16:                      v = 8'h3F;
            8'h1A:                      v = 8'h7F;
            8'h1B, 8'h20, 8'h48, 8'h49: v = 8'hFF;
            8'h1C:                      v = 8'h9F;
            8'h24:                      v = 8'h77;
            8'h26:                      v = 8'hF1;
            8'h40:                      v = 8'h91;
            8'h47:                      v = 8'hFC;
            default:                    v = 8'h00;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/iob_decode.sv
module iob_decode
    import iob_pkg::*;
(
    input  logic [AW-1:0] addr,
    output reg_class_e    cls,
    output logic [DW-1:0] mask
);
    always_comb begin
        cls  = classify(addr);
        mask = read_mask(addr);
    end
endmodule

// File: rtl/iob_store.sv
module iob_store
    import iob_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    input  reg_class_e    cls,
    output logic [DW-1:0] page_q,
    output logic [DW-1:0] ie_q,
    output logic          audio_en
);
    localparam int IW = $clog2(PAGE);

    logic [DW-1:0] mem [PAGE];
    logic [DW-1:0] store_val;
    logic          store_hit;
    logic [IW-1:0] idx;

    assign idx      = addr[IW-1:0];
    assign page_q   = mem[idx];
    assign audio_en = mem[A_AUDCTL[IW-1:0]][7];

    always_comb begin
        store_val = wdata;
        store_hit = we;
        unique case (cls)
            CLS_SOUND:   store_val = audio_en ? wdata : '0;
            CLS_AUDCTL:  store_val = {wdata[7], 3'b000, mem[A_AUDCTL[IW-1:0]][3:0]};
            CLS_IFLAG:   store_val = wdata | 8'hE0;
            CLS_DIV,
            CLS_IE,
            CLS_OUTSIDE: store_hit = 1'b0;
            default:     store_val = wdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE; i++) mem[i] <= reset_value(AW'(i));
            ie_q <= '0;
        end else begin
            if (store_hit) mem[idx] <= store_val;
            if (we && cls == CLS_IE) ie_q <= wdata;
        end
    end

    AST_AUDCTL_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cls == CLS_AUDCTL) |=> (mem[A_AUDCTL[IW-1:0]][3:0] == $past(mem[A_AUDCTL[IW-1:0]][3:0]))); // R5
    AST_IE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cls == CLS_IE) |=> (ie_q == $past(wdata))); // R7
endmodule

// File: rtl/iob_regbank.sv
module iob_regbank
    import iob_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_we,
    output logic [7:0]    bus_rdata,
    output logic          audio_en,
    output logic          snd_we,
    output logic [7:0]    snd_addr,
    output logic [7:0]    snd_wdata,
    output logic          div_reset,
    output logic          dma_start,
    output logic [15:0]   dma_src,
    output logic          irq_update
);
    reg_class_e    cls;
    logic [DW-1:0] mask;
    logic [DW-1:0] page_q;
    logic [DW-1:0] ie_q;

    iob_decode u_dec (.addr(bus_addr), .cls(cls), .mask(mask));

    iob_store u_store (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .cls(cls), .page_q(page_q), .ie_q(ie_q),
        .audio_en(audio_en)
    );

    always_comb begin
        unique case (cls)
            CLS_IE:                         bus_rdata = ie_q;
            CLS_NONE, CLS_OUTSIDE, CLS_DMA: bus_rdata = 8'hFF;
            default:                        bus_rdata = page_q | mask;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snd_we     <= 1'b0;
            snd_addr   <= '0;
            snd_wdata  <= '0;
            div_reset  <= 1'b0;
            dma_start  <= 1'b0;
            dma_src    <= '0;
            irq_update <= 1'b0;
        end else begin
            snd_we     <= bus_we && cls == CLS_SOUND && audio_en;
            div_reset  <= bus_we && cls == CLS_DIV;
            dma_start  <= bus_we && cls == CLS_DMA;
            irq_update <= bus_we && (cls == CLS_IFLAG || cls == CLS_IE);
            if (bus_we && cls == CLS_SOUND) begin
                snd_addr  <= bus_addr;
                snd_wdata <= bus_wdata;
            end
            if (bus_we && cls == CLS_DMA) dma_src <= {bus_wdata, 8'h00};
        end
    end

    AST_SND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        snd_we |-> $past(audio_en)); // R4
    AST_DIV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |-> $past(bus_we && bus_addr == A_DIV)); // R8
    AST_DMA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (dma_src == {$past(bus_wdata), 8'h00})); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_update |-> $past(bus_we && (bus_addr == A_IFLAG || bus_addr == A_IE))); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snd_we, div_reset, dma_start, irq_update})); // R11
endmodule

// File: tb/iob_regbank_tb.sv
module iob_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        audio_en, snd_we, div_reset, dma_start, irq_update;
    logic [7:0]  snd_addr, snd_wdata;
    logic [15:0] dma_src;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [128];
    logic [7:0] m_ie;
    logic       m_en;

    always #4 clk = ~clk;

    iob_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .audio_en(audio_en),
        .snd_we(snd_we), .snd_addr(snd_addr), .snd_wdata(snd_wdata),
        .div_reset(div_reset), .dma_start(dma_start), .dma_src(dma_src),
        .irq_update(irq_update)
    );

    function automatic bit is_sound(input int a);
        return (a >= 'h10 && a <= 'h25 && a != 'h15 && a != 'h1F);
    endfunction

    function automatic bit is_known(input int a);
        return is_sound(a) || (a >= 'h30 && a <= 'h3F) || a == 'h01 || a == 'h02 ||
               (a >= 'h04 && a <= 'h07) || a == 'h0F || a == 'h26 ||
               (a >= 'h40 && a <= 'h43) || a == 'h45 || (a >= 'h47 && a <= 'h4B);
    endfunction

    function automatic logic [7:0] mask_of(input int a);
        case (a)
            'h02: return 8'h7E;
            'h07: return 8'hF8;
            'h0F: return 8'hE0;
            'h10, 'h41: return 8'h80;
            'h11, 'h16: return 8'h3F;
            'h13, 'h18, 'h1B, 'h1D, 'h20: return 8'hFF;
            'h14, 'h19, 'h1E, 'h23: return 8'hBF;
            'h1A: return 8'h7F;
            'h1C: return 8'h9F;
            'h26: return 8'h70;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] expect_rd(input int a);
        if (a == 'hFF) return m_ie;
        if (a >= 'h80 || !is_known(a)) return 8'hFF;
        return model[a] | mask_of(a);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp, input int a);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%02h actual=%h expected=%h", req, a[7:0], act, exp);
        end
    endtask

    task automatic rd_check(input int a, input string req);
        @(negedge clk);
        bus_addr = 8'(a);
        #1;
        check(req, {8'h00, bus_rdata}, {8'h00, expect_rd(a)}, a);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bit e_snd, e_div, e_dma, e_irq;
        e_snd = 0; e_div = 0; e_dma = 0; e_irq = 0;
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
        if (a == 'hFF) begin m_ie = d; e_irq = 1; end
        else if (a >= 'h80) begin end
        else if (a == 'h04) e_div = 1;
        else if (a == 'h0F) begin model[a] = d | 8'hE0; e_irq = 1; end
        else if (a == 'h26) begin model[a] = {d[7], 3'b000, model[a][3:0]}; m_en = d[7]; end
        else if (is_sound(a)) begin model[a] = m_en ? d : 8'h00; e_snd = m_en; end
        else begin model[a] = d; e_dma = (a == 'h46); end
        @(negedge clk);
        bus_we = 1'b0;
        check("R11 snd_we", {15'd0, snd_we}, {15'd0, e_snd}, a);
        check("R8 div_reset", {15'd0, div_reset}, {15'd0, e_div}, a);
        check("R9 dma_start", {15'd0, dma_start}, {15'd0, e_dma}, a);
        check("R6 R7 irq_update", {15'd0, irq_update}, {15'd0, e_irq}, a);
        if (e_snd) check("R11 snd bus", {snd_addr, snd_wdata}, {8'(a), d}, a);
        if (e_dma) check("R9 dma_src", dma_src, {d, 8'h00}, a);
        check("R5 audio_en", {15'd0, audio_en}, {15'd0, m_en}, a);
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        model['h0F] = 8'hE1; model['h10] = 8'h80; model['h11] = 8'hBF; model['h12] = 8'hF3;
        model['h13] = 8'hF3; model['h14] = 8'hBF; model['h16] = 8'h3F; model['h19] = 8'hBF;
        model['h1A] = 8'h7F; model['h1B] = 8'hFF; model['h1C] = 8'h9F; model['h1E] = 8'hBF;
        model['h20] = 8'hFF; model['h23] = 8'hBF; model['h24] = 8'h77; model['h25] = 8'hF3;
        model['h26] = 8'hF1; model['h40] = 8'h91; model['h47] = 8'hFC; model['h48] = 8'hFF;
        model['h49] = 8'hFF;
        m_ie = 8'h00; m_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset defaults and R2/R3 masks across the full address space
        check("R1 audio_en", {15'd0, audio_en}, 16'd1, 'h26);
        check("R1 strobes idle", {12'd0, snd_we, div_reset, dma_start, irq_update}, 16'd0, 0);
        for (int a = 0; a < 256; a++) rd_check(a, "R1 R2 R3 reset read");
        // Sweep with audio enabled: R2 R3 R4 R6 R7 R8 R9 R10
        for (int a = 0; a < 256; a++) if (a != 'h26) wr(a, 8'(a) ^ 8'hA5);
        for (int a = 0; a < 256; a++) rd_check(a, "R2 R3 R10 sweep enabled");
        // R5: disable audio, nibble kept
        wr('h26, 8'h7F);
        rd_check('h26, "R5 audctl off");
        // R4: sound writes while disabled store zero
        for (int a = 0; a < 256; a++) if (a != 'h26) wr(a, 8'(a) ^ 8'h5A);
        for (int a = 0; a < 256; a++) rd_check(a, "R4 R3 sweep disabled");
        wr('h26, 8'h80);
        rd_check('h26, "R5 audctl on");
        wr('h11, 8'hC0);
        rd_check('h11, "R4 sound after enable");
        // R3 writes above the page do not alias into it
        wr('h85, 8'h33);
        rd_check('h05, "R3 no alias");
        wr('h0F, 8'h00);
        rd_check('h0F, "R6 flag forced");
        wr('hFF, 8'hE7);
        rd_check('hFF, "R7 ie unmasked");
        wr('h04, 8'hFF);
        rd_check('h04, "R8 div not stored");
        wr('h3F, 8'h00);
        rd_check('h3F, "R10 wave zero");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule